// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block measures how a processor core spends its cycles. It holds a 64-bit timestamp that advances on every clock, and two 40-bit event counters. Each event counter watches one of 42 event sources that the core reports every cycle. Each source reports an occurrence count of 0 to 2 on a two-bit lane, since two pipes can each produce one occurrence per cycle.

Software sets up and reads the unit through an indexed register port. Index 11h is the control word. Bits 15:0 configure counter 0, bits 25:16 configure counter 1, and every other bit is reserved. Counter 0 is at index 12h and counter 1 at index 13h. The privilege level of the running code gates counting. Each counter also drives a monitor pin, which pulses either on every increment or only when the counter wraps.

Within a 16-bit configuration field, the bits are as follows:
- Bits 5:0 hold the event code.
- Bit 6 allows counting at privilege levels 0 to 2.
- Bit 7 allows counting at level 3.
- Bit 8 selects cycle mode; when clear, the counter counts occurrences.
- Bit 9 selects overflow signalling on the pin; when clear, the pin pulses on each increment.

Top module: `perf_monitor`

## Requirements
- R1: `tsc_value` is 0 after reset and grows by exactly one on every clock edge, whatever the configuration or privilege.
- R2: Reset clears the control word and both counters, so indices 11h, 12h and 13h read as zero, and both monitor pins are low.
- R3: A write to index 11h keeps bits 9:0 of each 16-bit field. A read of index 11h returns those bits, with every reserved bit (15:10, 31:26, 63:32) reading as zero.
- R4: A write to index 12h or 13h loads the low 40 bits of the data into that counter, and a read returns the counter zero-extended to 64 bits. In a cycle where a counter is written, the write wins over any increment in that same cycle.
- R5: Event input lane k is `evt_occ[2k+1:2k]`, for k = 0 to 41. A counter looks only at the lane named by its event code.
- R6: At privilege 0, 1 or 2, counting requires field bit 6. At privilege 3, counting requires field bit 7. A counter whose enable is clear does not change.
- R7: With field bit 8 clear, a counter adds the selected lane's value (0, 1 or 2) on each clock edge.
- R8: With field bit 8 set, a counter adds 1 on each clock edge at which the selected lane is nonzero.
- R9: An event code of 2Ah or above never increments the counter, whatever the inputs.
- R10: The monitor pin is registered. With field bit 9 clear, the pin is high for the cycle after each edge at which the counter incremented. With field bit 9 set, the pin is high only for the cycle after an edge at which the counter wrapped past 2^40-1.
- R11: Writing the control word leaves both counter values unchanged.
- R12: A counter wraps modulo 2^40, keeping the excess. For example, 2^40-1 plus 2 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for the read and the write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_idx` (combinational) |
| evt_occ | input | 84 | Per-event occurrence counts, two bits per event code |
| priv | input | 2 | Current privilege level |
| tsc_value | output | 64 | Free-running timestamp |
| mon_pin | output | 2 | Monitor pin per counter |

## Verification
The assertions check several properties on every cycle:
- the timestamp steps by exactly one;
- a counter takes the written value after a write, and otherwise advances by exactly the increment;
- a cycle-mode counter never steps by more than one;
- an invalid event code or a disabled privilege level never produces an increment.

Only the directed scenarios can show the rest. These cover the exact totals produced by mixed occurrence patterns, the privilege and lane selection, reserved-bit masking on readback, and the write-over-increment priority. They also cover the wrap from 2^40-1 and the pin timing in both signalling modes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int CODE_W = 6;

   // Field layout: bit9 pin on overflow, bit8 cycle mode, bit7 user enable,
   // bit6 supervisor enable, bits 5:0 event code.
   typedef struct packed {
      logic              pin_ovf;
      logic              cyc_mode;
      logic              en_usr;
      logic              en_sys;
      logic [CODE_W-1:0] code;
   } pmu_cfg_t;

   localparam int CFG_W = $bits(pmu_cfg_t);
endpackage

// File: rtl/pmu_tstamp.sv
module pmu_tstamp #(
   parameter int TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts
);
   generate
      if (TS_W < 8) begin : g_bad_w
         $error("pmu_tstamp: TS_W too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ts <= '0;
      else        ts <= ts + TS_W'(1);
   end

   p_tsc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ts == $past(ts) + TS_W'(1));
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
   import pmu_pkg::*;
#(
   parameter int NUM_EVT = 42,
   parameter int OCC_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  pmu_cfg_t                 cfg,
   input  logic [NUM_EVT*OCC_W-1:0] evt_occ,
   input  logic [1:0]               priv,
   output logic [OCC_W-1:0]         inc
);
   generate
      if (NUM_EVT > (1 << CODE_W)) begin : g_bad_n
         $error("pmu_evt_sel: NUM_EVT exceeds event code space");
      end
   endgenerate

   logic [OCC_W-1:0] lane;
   logic             allowed;

   // Codes at or above NUM_EVT match no lane and leave lane at zero.
   always_comb begin
      lane = '0;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (cfg.code == CODE_W'(k)) lane = evt_occ[k*OCC_W +: OCC_W];
      end
   end

   assign allowed = (priv == 2'd3) ? cfg.en_usr : cfg.en_sys;

   always_comb begin
      if (!allowed)         inc = '0;
      else if (cfg.cyc_mode) inc = OCC_W'(lane != '0);
      else                  inc = lane;
   end

   p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg.code) >= NUM_EVT) |-> inc == '0);
   p_priv_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((priv == 2'd3 && !cfg.en_usr) || (priv != 2'd3 && !cfg.en_sys)) |-> inc == '0);
   p_cyc_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.cyc_mode |-> inc <= OCC_W'(1));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 40,
   parameter int INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic [INC_W-1:0] inc,
   input  logic             pin_ovf,
   output logic [CNT_W-1:0] cnt,
   output logic             pin
);
   generate
      if (INC_W >= CNT_W) begin : g_bad_w
         $error("pmu_counter: increment wider than counter");
      end
   endgenerate

   logic [CNT_W:0] sum;
   logic           wrap;

   assign sum  = {1'b0, cnt} + (CNT_W + 1)'(inc);
   assign wrap = sum[CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         pin <= 1'b0;
      end else if (wr_en) begin
         cnt <= wr_val;
         pin <= 1'b0;
      end else begin
         cnt <= sum[CNT_W-1:0];
         pin <= pin_ovf ? wrap : (inc != '0);
      end
   end

   p_wr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt == $past(wr_val));
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> cnt == $past(cnt) + CNT_W'($past(inc)));
   p_pin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && inc == '0) |=> !pin);
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
   import pmu_pkg::*;
#(
   parameter int              TS_W     = 64,
   parameter int              CNT_W    = 40,
   parameter int              N_CNT    = 2,
   parameter int              NUM_EVT  = 42,
   parameter int              OCC_W    = 2,
   parameter int              IDX_W    = 8,
   parameter int              DATA_W   = 64,
   parameter int              FIELD_W  = 16,
   parameter logic [IDX_W-1:0] IDX_CTL  = 8'h11,
   parameter logic [IDX_W-1:0] IDX_CNT0 = 8'h12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr_en,
   input  logic [IDX_W-1:0]         reg_idx,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic [NUM_EVT*OCC_W-1:0] evt_occ,
   input  logic [1:0]               priv,
   output logic [TS_W-1:0]          tsc_value,
   output logic [N_CNT-1:0]         mon_pin
);
   localparam int CTL_USED = N_CNT * FIELD_W;

   generate
      if (CTL_USED > DATA_W / 2) begin : g_bad_ctl
         $error("perf_monitor: configuration fields overrun the control word");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("perf_monitor: counter wider than data port");
      end
      if (CFG_W > FIELD_W) begin : g_bad_fld
         $error("perf_monitor: field narrower than configuration");
      end
   endgenerate

   pmu_cfg_t         cfg_q [N_CNT];
   logic [CNT_W-1:0] cnt_q [N_CNT];
   logic             ctl_wr;

   assign ctl_wr = reg_wr_en && (reg_idx == IDX_CTL);

   always_ff @(posedge clk) begin
      for (int i = 0; i < N_CNT; i++) begin
         if (!rst_n)      cfg_q[i] <= '0;
         else if (ctl_wr) cfg_q[i] <= pmu_cfg_t'(reg_wdata[i*FIELD_W +: CFG_W]);
      end
   end

   pmu_tstamp #(.TS_W(TS_W)) u_tstamp (
      .clk   (clk),
      .rst_n (rst_n),
      .ts    (tsc_value)
   );

   for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
      logic [OCC_W-1:0] inc;
      logic             cnt_wr;

      assign cnt_wr = reg_wr_en && (reg_idx == IDX_CNT0 + IDX_W'(g));

      pmu_evt_sel #(.NUM_EVT(NUM_EVT), .OCC_W(OCC_W)) u_sel (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg_q[g]),
         .evt_occ (evt_occ),
         .priv    (priv),
         .inc     (inc)
      );

      pmu_counter #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cnt_wr),
         .wr_val  (reg_wdata[CNT_W-1:0]),
         .inc     (inc),
         .pin_ovf (cfg_q[g].pin_ovf),
         .cnt     (cnt_q[g]),
         .pin     (mon_pin[g])
      );

      p_ctl_keeps_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_wr && inc == '0) |=> cnt_q[g] == $past(cnt_q[g]));
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_idx == IDX_CTL) begin
         for (int i = 0; i < N_CNT; i++) reg_rdata[i*FIELD_W +: CFG_W] = cfg_q[i];
      end
      for (int i = 0; i < N_CNT; i++) begin
         if (reg_idx == IDX_CNT0 + IDX_W'(i)) reg_rdata = DATA_W'(cnt_q[i]);
      end
   end
endmodule

// File: tb/perf_monitor_tb_top.sv
module perf_monitor_tb_top;
   localparam int NE = 42;
   localparam logic [63:0] TOP = (64'd1 << 40) - 64'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_idx = 8'h00;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [NE*2-1:0] evt_occ = '0;
   logic [1:0]  priv = 2'd0;
   logic [63:0] tsc_value;
   logic [1:0]  mon_pin;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   perf_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_occ(evt_occ),
      .priv(priv), .tsc_value(tsc_value), .mon_pin(mon_pin)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] idx, input logic [63:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] idx, output logic [63:0] d);
      reg_idx = idx;
      #1 d = reg_rdata;
   endtask

   task automatic lane(input int code, input logic [1:0] v);
      evt_occ = '0;
      evt_occ[code*2 +: 2] = v;
   endtask

   // drive a lane for n clock edges, then stop; called at a negedge
   task automatic drive(input int code, input logic [1:0] v, input int n);
      lane(code, v);
      repeat (n) @(negedge clk);
      evt_occ = '0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      rd(8'h11, d); chk("R2 ctl", d, 64'h0);
      rd(8'h12, d); chk("R2 cnt0", d, 64'h0);
      rd(8'h13, d); chk("R2 cnt1", d, 64'h0);
      chk("R2 pins", {62'h0, mon_pin}, 64'h0);
   endtask

   task automatic t_tsc();
      logic [63:0] a;
      a = tsc_value;
      repeat (5) @(negedge clk);
      chk("R1 step", tsc_value - a, 64'd5);
   endtask

   task automatic t_ctl();
      logic [63:0] d;
      wr(8'h11, '1);
      rd(8'h11, d); chk("R3 reserved mask", d, 64'h0000_0000_03FF_03FF);
   endtask

   task automatic t_occ();
      logic [63:0] d;
      wr(8'h11, 64'h0000_0040);
      wr(8'h12, 0); wr(8'h13, 0);
      priv = 2'd0;
      drive(0, 2'd2, 3);
      drive(0, 2'd1, 2);
      rd(8'h12, d); chk("R7 occurrence sum", d, 64'd8);
      drive(1, 2'd2, 3);
      rd(8'h12, d); chk("R5 other lane ignored", d, 64'd8);
      rd(8'h13, d); chk("R6 disabled counter", d, 64'd0);
   endtask

   task automatic t_cyc();
      logic [63:0] d;
      wr(8'h11, 64'h0000_015F);
      wr(8'h12, 0);
      drive(31, 2'd2, 4);
      drive(31, 2'd1, 2);
      rd(8'h12, d); chk("R8 cycle mode", d, 64'd6);
   endtask

   task automatic t_priv();
      logic [63:0] d;
      wr(8'h11, 64'h0057_0097);
      wr(8'h12, 0); wr(8'h13, 0);
      priv = 2'd0; drive(23, 2'd1, 3);
      priv = 2'd3; drive(23, 2'd1, 2);
      priv = 2'd2; drive(23, 2'd1, 1);
      priv = 2'd0;
      rd(8'h12, d); chk("R6 user-only counter", d, 64'd2);
      rd(8'h13, d); chk("R6 supervisor-only counter", d, 64'd4);
   endtask

   task automatic t_bad();
      logic [63:0] d;
      wr(8'h11, 64'h01FF_00EA);
      wr(8'h12, 0); wr(8'h13, 0);
      for (int k = 0; k < NE; k++) evt_occ[k*2 +: 2] = 2'd2;
      priv = 2'd0; repeat (2) @(negedge clk);
      chk("R9 pins quiet", {62'h0, mon_pin}, 64'h0);
      priv = 2'd3; repeat (2) @(negedge clk);
      evt_occ = '0; priv = 2'd0;
      rd(8'h12, d); chk("R9 code 2Ah", d, 64'd0);
      rd(8'h13, d); chk("R9 code 3Fh", d, 64'd0);
   endtask

   task automatic t_wr();
      logic [63:0] d;
      wr(8'h11, 64'h0000_0040);
      wr(8'h12, 64'hFFFF_FF12_3456_789A);
      rd(8'h12, d); chk("R4 low 40 bits", d, 64'h0000_0012_3456_789A);
      @(negedge clk);
      lane(0, 2'd2);
      reg_wr_en = 1'b1; reg_idx = 8'h12; reg_wdata = 64'h55;
      @(negedge clk);
      reg_wr_en = 1'b0; evt_occ = '0;
      rd(8'h12, d); chk("R4 write wins", d, 64'h55);
      wr(8'h11, 64'h0000_005F);
      rd(8'h12, d); chk("R11 control write keeps count", d, 64'h55);
   endtask

   task automatic t_pin_inc();
      logic [63:0] d;
      wr(8'h11, 64'h0000_0040);
      wr(8'h12, 0);
      @(negedge clk);
      lane(0, 2'd1);
      @(negedge clk);
      chk("R10 increment pulse", {62'h0, mon_pin}, 64'h1);
      evt_occ = '0;
      @(negedge clk);
      chk("R10 pulse ends", {62'h0, mon_pin}, 64'h0);
      rd(8'h12, d); chk("R7 single", d, 64'd1);
   endtask

   task automatic t_ovf();
      logic [63:0] d;
      wr(8'h11, 64'h0000_0240);
      wr(8'h12, TOP - 64'd3);
      @(negedge clk);
      lane(0, 2'd1);
      @(negedge clk);
      chk("R10 no pulse without wrap", {62'h0, mon_pin}, 64'h0);
      lane(0, 2'd2);
      @(negedge clk);
      rd(8'h12, d); chk("R12 reach top", d, TOP);
      chk("R10 no pulse at top", {62'h0, mon_pin}, 64'h0);
      lane(0, 2'd2);
      @(negedge clk);
      evt_occ = '0;
      rd(8'h12, d); chk("R12 wrap keeps excess", d, 64'd1);
      chk("R10 overflow pulse", {62'h0, mon_pin}, 64'h1);
      @(negedge clk);
      chk("R10 overflow pulse ends", {62'h0, mon_pin}, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tsc();
      t_ctl();
      t_occ();
      t_cyc();
      t_priv();
      t_bad();
      t_wr();
      t_pin_inc();
      t_ovf();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule